// File: doc/BRIEF.md
# Bus-mapped JTAG port bridge

This block places a JTAG chain at one address of a processor's parallel bus. Firmware drives the chain by writing to that address, one bus write per pin change. Each write loads three registers that drive TDI, TMS and TCK. A read at the same address returns the live TDO level together with the three register values, so software can confirm what it last wrote. All three JTAG outputs change only on the system clock, and never follow the bus combinationally.

A select input hands the chain over to an external download-cable header. While the cable is selected, the cable's TDI, TMS and TCK reach the chain through a 2-to-1 multiplexer per signal, and TDO is routed back out to the cable. Bus writes are dropped during that time. The registers keep their values, so the processor path resumes where it left off once the select is released.

The data bus has separate input, output and output-enable signals for a pad-level tri-state driver. The output enable is high only during a qualified read of the JTAG address.

Top module: `jtag_bus_bridge`

## Requirements
- R1: An access is qualified only when all of the following hold: addr_i equals the JTAG_ADDR parameter, as_i is high and ds_ni is low. A write at any other address, or with as_i low or ds_ni high, leaves the registers unchanged.
- R2: A qualified write (rnw_i=0) loads data_i bit 0 into TCK, bit 1 into TMS and bit 2 into TDI on the rising clock edge. The new values appear on tck_o, tms_o and tdi_o after that edge.
- R3: While the processor path is selected, tck_o, tms_o and tdi_o change only at a clock edge on which a qualified write was sampled. Bus activity between edges has no effect on them.
- R4: During a qualified read (rnw_i=1), data_oe_o is high and data_o carries the following bits: bit 3 is the present tdo_i level, bit 2 is TDI, bit 1 is TMS and bit 0 is TCK from the registers. The read value follows tdo_i combinationally.
- R5: data_oe_o is low whenever the access is not a qualified read. This covers writes, other addresses, as_i low and ds_ni high.
- R6: With cable_sel_i=1, tdi_o, tms_o and tck_o equal cable_tdi_i, cable_tms_i and cable_tck_i, and cable_tdo_o equals tdo_i. With cable_sel_i=0, cable_tdo_o is 0.
- R7: Writes sampled while cable_sel_i=1 are ignored. After cable_sel_i returns to 0, the outputs show the register values held before the cable was selected.
- R8: An active-low asynchronous reset on rst_ni clears TCK, TMS and TDI to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 20 | Processor address bus |
| rnw_i | input | 1 | 1 = read, 0 = write |
| as_i | input | 1 | Address strobe, active high |
| ds_ni | input | 1 | Data strobe, active low |
| data_i | input | 4 | Write data from the bus |
| data_o | output | 4 | Read data to the bus pad |
| data_oe_o | output | 1 | Tri-state enable for data_o |
| cable_sel_i | input | 1 | 1 = download cable drives the chain |
| cable_tdi_i | input | 1 | Cable TDI |
| cable_tms_i | input | 1 | Cable TMS |
| cable_tck_i | input | 1 | Cable TCK |
| cable_tdo_o | output | 1 | TDO returned to the cable |
| tdi_o | output | 1 | Chain TDI |
| tms_o | output | 1 | Chain TMS |
| tck_o | output | 1 | Chain TCK |
| tdo_i | input | 1 | Chain TDO |

## Verification
The bench targets near-miss accesses: an address one bit off, a missing address strobe, and an inactive data strobe. A decoder that ignored any of these terms would corrupt the JTAG pins or drive the bus when it should float. It toggles tdo_i during reads held over several cycles, which catches a read path that latches TDO instead of passing it through. It also writes while the cable owns the chain and then releases the select. A design that failed to gate writes, or that reset the registers on handover, would show stale or cleared values afterwards. A bench-side model runs in step with the design and is compared after every falling edge, so an output that moved without a write or a wrongly ordered bit shows at once.

// File: rtl/jtag_bridge_pkg.sv
package jtag_bridge_pkg;
  localparam int TCK_BIT = 0;
  localparam int TMS_BIT = 1;
  localparam int TDI_BIT = 2;
  localparam int TDO_BIT = 3;
  localparam int NUM_DRV = 3;

  typedef struct packed {
    logic tdi;
    logic tms;
    logic tck;
  } jtag_drv_t;
endpackage

// File: rtl/jtag_addr_match.sv
module jtag_addr_match #(
  parameter int              ADDR_W    = 20,
  parameter logic [ADDR_W-1:0] JTAG_ADDR = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              as_i,
  input  logic              ds_ni,
  output logic              hit_o
);
  assign hit_o = (addr_i == JTAG_ADDR) && as_i && !ds_ni;
endmodule

// File: rtl/jtag_drive_regs.sv
module jtag_drive_regs
  import jtag_bridge_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output jtag_drv_t         q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else if (load_i) begin
      q_o.tck <= data_i[TCK_BIT];
      q_o.tms <= data_i[TMS_BIT];
      q_o.tdi <= data_i[TDI_BIT];
    end
  end
endmodule

// File: rtl/jtag_route_mux.sv
module jtag_route_mux #(
  parameter int N = 3
) (
  input  logic         cable_sel_i,
  input  logic [N-1:0] proc_i,
  input  logic [N-1:0] cable_i,
  output logic [N-1:0] out_o
);
  for (genvar g = 0; g < N; g++) begin : g_sig
    assign out_o[g] = cable_sel_i ? cable_i[g] : proc_i[g];
  end
endmodule

// File: rtl/jtag_bus_bridge.sv
module jtag_bus_bridge
  import jtag_bridge_pkg::*;
#(
  parameter int                ADDR_W    = 20,
  parameter int                DATA_W    = 4,
  parameter logic [ADDR_W-1:0] JTAG_ADDR = 20'hA5F00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rnw_i,
  input  logic              as_i,
  input  logic              ds_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic              cable_sel_i,
  input  logic              cable_tdi_i,
  input  logic              cable_tms_i,
  input  logic              cable_tck_i,
  output logic              cable_tdo_o,
  output logic              tdi_o,
  output logic              tms_o,
  output logic              tck_o,
  input  logic              tdo_i
);
  logic      hit;
  logic      wr_en;
  jtag_drv_t drv_q;
  logic [NUM_DRV-1:0] chain_out;

  jtag_addr_match #(.ADDR_W(ADDR_W), .JTAG_ADDR(JTAG_ADDR)) u_match (
    .addr_i(addr_i), .as_i(as_i), .ds_ni(ds_ni), .hit_o(hit)
  );

  // cable ownership blocks processor writes, registers hold
  assign wr_en = hit && !rnw_i && !cable_sel_i;

  jtag_drive_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(wr_en), .data_i(data_i), .q_o(drv_q)
  );

  jtag_route_mux #(.N(NUM_DRV)) u_mux (
    .cable_sel_i(cable_sel_i),
    .proc_i(drv_q),
    .cable_i({cable_tdi_i, cable_tms_i, cable_tck_i}),
    .out_o(chain_out)
  );

  assign {tdi_o, tms_o, tck_o} = chain_out;
  assign cable_tdo_o = cable_sel_i && tdo_i;

  assign data_oe_o = hit && rnw_i;
  always_comb begin
    data_o          = '0;
    data_o[TCK_BIT] = drv_q.tck;
    data_o[TMS_BIT] = drv_q.tms;
    data_o[TDI_BIT] = drv_q.tdi;
    data_o[TDO_BIT] = tdo_i;
  end
endmodule

// File: rtl/jtag_bus_bridge_chk.sv
module jtag_bus_bridge_chk #(
  parameter int                ADDR_W    = 20,
  parameter int                DATA_W    = 4,
  parameter logic [ADDR_W-1:0] JTAG_ADDR = 20'hA5F00
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rnw_i,
  input logic              as_i,
  input logic              ds_ni,
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic              cable_sel_i,
  input logic              cable_tck_i,
  input logic              cable_tdo_o,
  input logic              tdi_o,
  input logic              tms_o,
  input logic              tck_o,
  input logic              tdo_i,
  input logic [2:0]        drv_q
);
  logic acc, wr_ev, rd_ev;
  assign acc   = (addr_i == JTAG_ADDR) && as_i && !ds_ni;
  assign wr_ev = rst_ni && acc && !rnw_i && !cable_sel_i;
  assign rd_ev = acc && rnw_i;

  p_write_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_ev) && !cable_sel_i |-> {tdi_o, tms_o, tck_o} == $past(data_i[2:0]));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(wr_ev) && !cable_sel_i && !$past(cable_sel_i)
      |-> $stable({tdi_o, tms_o, tck_o}));

  p_read_tdo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ev |-> data_oe_o && (data_o[3] == tdo_i));

  p_float_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_ev |-> !data_oe_o);

  p_cable_route_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cable_sel_i |-> (tck_o == cable_tck_i) && (cable_tdo_o == tdo_i));

  p_cable_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cable_sel_i |=> $stable(drv_q));
endmodule

bind jtag_bus_bridge jtag_bus_bridge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .JTAG_ADDR(JTAG_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rnw_i(rnw_i), .as_i(as_i),
  .ds_ni(ds_ni), .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o),
  .cable_sel_i(cable_sel_i), .cable_tck_i(cable_tck_i), .cable_tdo_o(cable_tdo_o),
  .tdi_o(tdi_o), .tms_o(tms_o), .tck_o(tck_o), .tdo_i(tdo_i), .drv_q(drv_q)
);

// File: tb/sim_jtag_bus_bridge.sv
`timescale 1ns/1ps
module sim_jtag_bus_bridge;
  localparam logic [19:0] JA = 20'hA5F00;

  logic clk = 0, rst_ni = 0;
  logic [19:0] addr = 0;
  logic rnw = 1, as_s = 0, ds_n = 1;
  logic [3:0] din = 0;
  logic [3:0] dout;
  logic oe, ctdo, tdi, tms, tck;
  logic csel = 0, ctdi = 0, ctms = 0, ctck = 0, tdo = 0;

  always #2.5 clk = ~clk;

  jtag_bus_bridge u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .rnw_i(rnw), .as_i(as_s),
    .ds_ni(ds_n), .data_i(din), .data_o(dout), .data_oe_o(oe),
    .cable_sel_i(csel), .cable_tdi_i(ctdi), .cable_tms_i(ctms), .cable_tck_i(ctck),
    .cable_tdo_o(ctdo), .tdi_o(tdi), .tms_o(tms), .tck_o(tck), .tdo_i(tdo)
  );

  int checks = 0, failures = 0;
  bit run = 0, done = 0;
  string req = "R8";

  // behavioural model: {tdi,tms,tck}
  bit m_tck, m_tms, m_tdi;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_tck = 0; m_tms = 0; m_tdi = 0;
    end else if (addr == JA && as_s && !ds_n && !rnw && !csel) begin
      m_tck = din[0]; m_tms = din[1]; m_tdi = din[2];
    end
  end

  always @(negedge clk) begin
    #1;
    if (run && !done) begin
      bit e_tck, e_tms, e_tdi, e_oe, e_ctdo;
      bit [3:0] e_d;
      e_tck  = csel ? ctck : m_tck;
      e_tms  = csel ? ctms : m_tms;
      e_tdi  = csel ? ctdi : m_tdi;
      e_ctdo = csel ? tdo : 1'b0;
      e_oe   = (addr == JA) && as_s && !ds_n && rnw;
      e_d    = {tdo, m_tdi, m_tms, m_tck};
      checks++;
      if ({tdi, tms, tck, ctdo} !== {e_tdi, e_tms, e_tck, e_ctdo}) begin
        failures++;
        $display("FAIL %s chain pins tdi/tms/tck/ctdo act=%b%b%b%b exp=%b%b%b%b",
                 req, tdi, tms, tck, ctdo, e_tdi, e_tms, e_tck, e_ctdo);
      end
      checks++;
      if (oe !== e_oe || (e_oe && dout !== e_d)) begin
        failures++;
        $display("FAIL %s bus oe/data act=%b/%h exp=%b/%h", req, oe, dout, e_oe, e_d);
      end
    end
  end

  task automatic cyc(input logic [19:0] a, input logic r, input logic s,
                     input logic dn, input logic [3:0] d);
    @(negedge clk);
    addr = a; rnw = r; as_s = s; ds_n = dn; din = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(20'h0, 1'b1, 1'b0, 1'b1, 4'h0);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    run = 1;
    req = "R8";
    idle(3);
    rst_ni = 1;
    idle(2);

    req = "R2";
    for (int v = 0; v < 8; v++) begin
      cyc(JA, 1'b0, 1'b1, 1'b0, 4'(v));
      idle(1);
    end

    req = "R4";
    cyc(JA, 1'b0, 1'b1, 1'b0, 4'h5);
    for (int i = 0; i < 6; i++) begin
      cyc(JA, 1'b1, 1'b1, 1'b0, 4'h0);
      tdo = ~tdo;
    end
    idle(1);

    req = "R1";
    cyc(JA ^ 20'h1, 1'b0, 1'b1, 1'b0, 4'h2);
    cyc(JA ^ 20'h80000, 1'b0, 1'b1, 1'b0, 4'h3);
    cyc(JA, 1'b0, 1'b0, 1'b0, 4'h2);
    cyc(JA, 1'b0, 1'b1, 1'b1, 4'h7);
    idle(1);

    req = "R5";
    cyc(JA, 1'b1, 1'b1, 1'b1, 4'h0);
    cyc(JA, 1'b1, 1'b0, 1'b0, 4'h0);
    cyc(JA ^ 20'h10, 1'b1, 1'b1, 1'b0, 4'h0);
    cyc(JA, 1'b0, 1'b1, 1'b0, 4'h6);
    idle(1);

    req = "R3";
    for (int i = 0; i < 4; i++) cyc(JA, 1'b0, 1'b0, 1'b0, 4'(i + 1));
    cyc(JA, 1'b0, 1'b1, 1'b0, 4'h1);
    cyc(JA, 1'b0, 1'b1, 1'b0, 4'h1);
    idle(2);

    req = "R6";
    @(negedge clk) csel = 1;
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      {ctdi, ctms, ctck} = 3'(v);
      tdo = v[0];
    end

    req = "R7";
    cyc(JA, 1'b0, 1'b1, 1'b0, 4'h6);
    cyc(JA, 1'b0, 1'b1, 1'b0, 4'h7);
    cyc(JA, 1'b1, 1'b1, 1'b0, 4'h0);
    idle(1);
    @(negedge clk) csel = 0;
    cyc(JA, 1'b1, 1'b1, 1'b0, 4'h0);
    idle(2);

    req = "R8";
    cyc(JA, 1'b0, 1'b1, 1'b0, 4'h7);
    idle(1);
    #1 rst_ni = 0;
    idle(2);
    rst_ni = 1;
    cyc(JA, 1'b1, 1'b1, 1'b0, 4'h0);
    idle(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule